// File: doc/BRIEF.md
# Two-Wire Bus Condition and Status Monitor

This block watches the clock and data lines of a two-wire serial bus (I2C style) and turns what it sees into an 8-bit status code. Both lines are first synchronized into the local clock domain. The block then picks out START and STOP conditions and follows the bit position inside each nine-pulse frame, which is eight data bits plus an acknowledge bit. Each event that matters loads a fresh status code and raises a sticky event flag. A START or STOP that lands partway through a frame is reported as a bus error.

Software reaches the block through a single control byte. From it, software can enable the monitor, enable the interrupt, clear the event flag by writing 1 to it, and leave a STOP request that hardware drops once a STOP appears on the bus. The block never drives the bus, shifts no data and runs no master or slave sequence. It only observes and reports.

Top module: `bw_bus_watch`

## Requirements
- R1: After reset the status reads 0xF8, the control byte reads 0x00 and `irq` is low.
- R2: While the enable bit (control bit 6) is 1, the block posts a status code for each bus condition seen at a frame boundary. A START (SDA falling while SCL is high) on an idle bus posts 0x08. A START while a transfer is still open posts 0x10. A STOP (SDA rising while SCL is high) posts 0xA0. Each code appears on the third rising clock edge after the line changes.
- R3: After a START, every group of nine SCL pulses forms one frame. On the falling edge of the ninth pulse the block posts 0x28 if SDA was low at that pulse's rising edge, and 0x30 if it was high. Nothing is posted between the frame's first and ninth pulses.
- R4: A START or STOP seen after the first SCL pulse of a frame has completed and before the ninth has completed posts 0x00. A START that arrives this way still opens a new frame.
- R5: Posting any code other than 0xF8 sets the event flag, which reads as control bit 3. A control write with bit 3 at 1 clears the flag. A write with bit 3 at 0 leaves it as it was.
- R6: `irq` is high exactly while the event flag and the interrupt-enable bit (control bit 7) are both 1.
- R7: When a status post and a flag-clearing write fall in the same clock cycle, the flag ends that cycle set.
- R8: A control write stores bits 7, 6, 5, 4 and 2 as written. Bits 1:0 always read 0, and bit 3 reads the event flag.
- R9: The STOP-request bit (control bit 4) is cleared by hardware when a STOP is seen while the block is enabled. A control write in the same cycle takes precedence.
- R10: While the enable bit is 0, the status reads 0xF8 from the next clock on and the frame position is held at zero. Bus activity in this state posts no code, leaves the flag alone and does not clear the STOP-request bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_rdata | output | 8 | Control byte read value, with the event flag at bit 3 |
| status | output | 8 | Current bus status code |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land in the same clock cycle: hardware posting a new status code, and software writing 1 to clear the event flag. To force the collision, the bench times a flag-clearing write so that it reaches the edge on which a STOP's 0xA0 is loaded, which is three edges after SDA rises. It then requires the flag to read 1 afterwards, next to the new code. A second overlap of the same kind exists between a write to the STOP-request bit and a STOP being observed. A behavioural model checks that overlap on every cycle together with the status code and the interrupt line.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef enum logic [7:0] {
        ST_ERR    = 8'h00,
        ST_START  = 8'h08,
        ST_RSTART = 8'h10,
        ST_ACK    = 8'h28,
        ST_NACK   = 8'h30,
        ST_STOP   = 8'hA0,
        ST_IDLE   = 8'hF8
    } bus_code_e;

    // Line events seen after synchronization, one cycle wide.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } line_ev_t;

    // Control byte; field order gives the bit position (MSB first).
    typedef struct packed {
        logic       irq_en;    // bit 7
        logic       enable;    // bit 6
        logic       start_req; // bit 5
        logic       stop_req;  // bit 4
        logic       flag;      // bit 3
        logic       ack_en;    // bit 2
        logic [1:0] rsv;       // bits 1:0
    } ctrl_t;

    function automatic logic code_raises_flag(bus_code_e c);
        return c != ST_IDLE;
    endfunction

endpackage

// File: rtl/bw_line_sync.sv
module bw_line_sync
    import bw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_in;
                    sda_pipe[g] <= sda_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        ev.sda      = sda_now;
        ev.start    = sda_prev & ~sda_now & scl_now;
        ev.stop     = ~sda_prev & sda_now & scl_now;
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
    end

endmodule

// File: rtl/bw_frame_track.sv
module bw_frame_track
    import bw_pkg::*;
#(
    parameter int   FRAME_BITS = 9,
    localparam int  POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  line_ev_t         ev,
    output logic             post_vld,
    output bus_code_e        post_code,
    output logic [POS_W-1:0] bit_pos
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic busy;     // a START has been seen and no STOP since
    logic hi_seen;  // SCL rose inside the current bit
    logic ack_bit;  // SDA sampled on the last bit's rising edge

    logic boundary;
    logic frame_end;

    assign boundary  = (bit_pos == '0);
    assign frame_end = busy && ev.scl_fall && hi_seen && (bit_pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            bit_pos <= '0;
            busy    <= 1'b0;
            hi_seen <= 1'b0;
            ack_bit <= 1'b1;
        end else if (ev.start) begin
            busy    <= 1'b1;
            bit_pos <= '0;
            hi_seen <= 1'b0;
        end else if (ev.stop) begin
            busy    <= 1'b0;
            bit_pos <= '0;
            hi_seen <= 1'b0;
        end else if (busy) begin
            if (ev.scl_rise) begin
                hi_seen <= 1'b1;
                if (bit_pos == LAST_POS) begin
                    ack_bit <= ev.sda;
                end
            end
            if (ev.scl_fall && hi_seen) begin
                hi_seen <= 1'b0;
                bit_pos <= (bit_pos == LAST_POS) ? '0 : bit_pos + 1'b1;
            end
        end
    end

    always_comb begin
        post_vld  = 1'b0;
        post_code = ST_IDLE;
        if (en) begin
            if (ev.start) begin
                post_vld  = 1'b1;
                post_code = !boundary ? ST_ERR : (busy ? ST_RSTART : ST_START);
            end else if (ev.stop) begin
                post_vld  = 1'b1;
                post_code = !boundary ? ST_ERR : ST_STOP;
            end else if (frame_end) begin
                post_vld  = 1'b1;
                post_code = ack_bit ? ST_NACK : ST_ACK;
            end
        end
    end

    // R3: the bit position never runs past the last bit of a frame
    a_r3_pos_bound: assert property (@(posedge clk) disable iff (rst)
        bit_pos <= LAST_POS);

    // R10: a disabled monitor holds the frame position at zero
    a_r10_pos_cleared: assert property (@(posedge clk) disable iff (rst)
        !en |=> bit_pos == '0);

endmodule

// File: rtl/bw_ctrl_regs.sv
module bw_ctrl_regs
    import bw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [7:0] wdata,
    input  logic      post_vld,
    input  bus_code_e post_code,
    input  logic      stop_seen,
    output ctrl_t     ctrl,
    output logic [7:0] status,
    output logic      irq
);

    ctrl_t wv;
    logic  unused_rsv;

    assign wv         = ctrl_t'(wdata);
    assign unused_rsv = ^wv.rsv;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            status <= ST_IDLE;
        end else begin
            if (!ctrl.enable) begin
                status <= ST_IDLE;
            end else if (post_vld) begin
                status <= post_code;
            end

            // R7: a new post outranks a clearing write
            if (post_vld && code_raises_flag(post_code)) begin
                ctrl.flag <= 1'b1;
            end else if (wr && wv.flag) begin
                ctrl.flag <= 1'b0;
            end

            // R9: software write outranks the hardware clear
            if (wr) begin
                ctrl.stop_req <= wv.stop_req;
            end else if (stop_seen) begin
                ctrl.stop_req <= 1'b0;
            end

            if (wr) begin
                ctrl.irq_en    <= wv.irq_en;
                ctrl.enable    <= wv.enable;
                ctrl.start_req <= wv.start_req;
                ctrl.ack_en    <= wv.ack_en;
            end
            ctrl.rsv <= 2'b00;
        end
    end

    assign irq = ctrl.flag & ctrl.irq_en;

    // R5: the flag survives every cycle without a clearing write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl.flag && !(wr && wdata[3]) |=> ctrl.flag);

    // R7: post and clear together leave the flag set
    a_r7_post_wins: assert property (@(posedge clk) disable iff (rst)
        post_vld && code_raises_flag(post_code) && wr && wdata[3] |=> ctrl.flag);

    // R10: disabled means the idle code one cycle later
    a_r10_idle_code: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> status == ST_IDLE);

endmodule

// File: rtl/bw_bus_watch.sv
module bw_bus_watch
    import bw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    output logic [7:0] status,
    output logic       irq
);

    localparam int POS_W = $clog2(FRAME_BITS);

    line_ev_t         ev;
    logic             post_vld;
    bus_code_e        post_code;
    logic [POS_W-1:0] bit_pos;
    ctrl_t            ctrl;

    bw_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    bw_frame_track #(
        .FRAME_BITS (FRAME_BITS)
    ) i_track (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.enable),
        .ev        (ev),
        .post_vld  (post_vld),
        .post_code (post_code),
        .bit_pos   (bit_pos)
    );

    bw_ctrl_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (ctrl_wr),
        .wdata     (ctrl_wdata),
        .post_vld  (post_vld),
        .post_code (post_code),
        .stop_seen (ev.stop & ctrl.enable),
        .ctrl      (ctrl),
        .status    (status),
        .irq       (irq)
    );

    assign ctrl_rdata = ctrl;

    // R4: a condition inside a frame is reported as a bus error
    a_r4_midframe_error: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) && ctrl.enable && bit_pos != '0 |=> status == ST_ERR);

    // R9: an observed STOP drops the request when no write competes
    a_r9_stop_req_drop: assert property (@(posedge clk) disable iff (rst)
        ev.stop && ctrl.enable && !ctrl_wr |=> !ctrl_rdata[4]);

endmodule

// File: tb/test_bw_bus_watch.sv
`timescale 1ns/1ps
module test_bw_bus_watch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic [7:0] status;
    logic       irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  live  = 1'b0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    bw_bus_watch i_bw_bus_watch (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .status     (status),
        .irq        (irq)
    );

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // line history: index 0 newest sample, 2 oldest
    logic [2:0] hs, hd;
    int  m_pos, m_stat;
    bit  m_hi, m_busy, m_ackb;
    bit  m_ie, m_en, m_sta, m_sto, m_flag, m_aa;
    bit  e_st, e_sp, e_rs, e_fl, e_pv;
    int  e_code;

    always @(posedge clk) begin
        if (rst) begin
            hs = 3'b111; hd = 3'b111;
            m_pos = 0; m_hi = 0; m_busy = 0; m_ackb = 1;
            m_ie = 0; m_en = 0; m_sta = 0; m_sto = 0; m_flag = 0; m_aa = 0;
            m_stat = 'hF8;
        end else begin
            e_st = m_en && hd[2] && !hd[1] && hs[1];
            e_sp = m_en && !hd[2] && hd[1] && hs[1];
            e_rs = m_en && hs[1] && !hs[2];
            e_fl = m_en && !hs[1] && hs[2];
            e_pv = 0; e_code = 'hF8;
            if (!m_en) begin
                m_pos = 0; m_hi = 0; m_busy = 0; m_ackb = 1;
            end else if (e_st) begin
                e_pv = 1;
                e_code = (m_pos != 0) ? 'h00 : (m_busy ? 'h10 : 'h08);
                m_busy = 1; m_pos = 0; m_hi = 0;
            end else if (e_sp) begin
                e_pv = 1;
                e_code = (m_pos != 0) ? 'h00 : 'hA0;
                m_busy = 0; m_pos = 0; m_hi = 0;
            end else if (m_busy) begin
                if (e_rs) begin
                    m_hi = 1;
                    if (m_pos == 8) m_ackb = hd[1];
                end
                if (e_fl && m_hi) begin
                    m_hi = 0;
                    if (m_pos == 8) begin
                        e_pv = 1; e_code = m_ackb ? 'h30 : 'h28; m_pos = 0;
                    end else begin
                        m_pos++;
                    end
                end
            end
            if (!m_en) m_stat = 'hF8;
            else if (e_pv) m_stat = e_code;
            if (e_pv && e_code != 'hF8) m_flag = 1;
            else if (ctrl_wr && ctrl_wdata[3]) m_flag = 0;
            if (ctrl_wr) m_sto = ctrl_wdata[4];
            else if (e_sp) m_sto = 0;
            if (ctrl_wr) begin
                m_ie = ctrl_wdata[7]; m_en = ctrl_wdata[6];
                m_sta = ctrl_wdata[5]; m_aa = ctrl_wdata[2];
            end
            hs = {hs[1:0], scl_in};
            hd = {hd[1:0], sda_in};
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            chk("R2 status vs model", status, 8'(m_stat));
            chk("R8 control vs model", ctrl_rdata,
                {m_ie, m_en, m_sta, m_sto, m_flag, m_aa, 2'b00});
            chk("R6 irq vs model", {7'd0, irq}, {7'd0, m_flag & m_ie});
        end
    end

    // ---------------- stimulus ----------------
    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic bus_bit(bit b);
        sda_in = b; hold(4);
        scl_in = 1'b1; hold(4);
        scl_in = 1'b0; hold(4);
    endtask

    task automatic bus_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    endtask

    task automatic bus_start;
        sda_in = 1'b1; hold(2);
        scl_in = 1'b1; hold(4);
        sda_in = 1'b0; hold(4);
        scl_in = 1'b0; hold(4);
    endtask

    task automatic bus_stop;
        sda_in = 1'b0; hold(4);
        scl_in = 1'b1; hold(4);
        sda_in = 1'b1; hold(4);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        hold(3);
        rst = 1'b0;
        live = 1'b1;
        // R1 reset state
        chk("R1 status", status, 8'hF8);
        chk("R1 control", ctrl_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R10 disabled: bus traffic ignored
        bus_start(); bus_bit(1); bus_bit(0); bus_bit(1); bus_stop();
        chk("R10 status while disabled", status, 8'hF8);
        chk("R10 flag while disabled", ctrl_rdata, 8'h00);

        // R2 START from idle, R5 flag, R6 irq
        cpu_write(8'hC0);
        bus_start();
        chk("R2 start code", status, 8'h08);
        chk("R5 flag set", ctrl_rdata, 8'hC8);
        chk("R6 irq high", {7'd0, irq}, 8'h01);

        // R5 write with bit 3 low keeps flag, high clears
        cpu_write(8'hC0);
        chk("R5 flag kept", ctrl_rdata, 8'hC8);
        cpu_write(8'hC8);
        chk("R5 flag cleared", ctrl_rdata, 8'hC0);
        chk("R6 irq low", {7'd0, irq}, 8'h00);

        // R3 no post mid-frame, then ACK frame
        bus_byte(8'hA5);
        chk("R3 no post inside frame", status, 8'h08);
        chk("R3 flag quiet inside frame", ctrl_rdata, 8'hC0);
        bus_bit(0);
        chk("R3 ack code", status, 8'h28);
        chk("R5 flag after frame", ctrl_rdata, 8'hC8);

        // R2 repeated START, R3 NACK frame
        bus_start();
        chk("R2 repeated start code", status, 8'h10);
        bus_byte(8'h3C);
        bus_bit(1);
        chk("R3 nack code", status, 8'h30);

        // R8 control layout
        cpu_write(8'hFF);
        chk("R8 readback", ctrl_rdata, 8'hF4);

        // R9 STOP drops request, R2 stop code
        bus_stop();
        chk("R2 stop code", status, 8'hA0);
        chk("R9 request cleared", ctrl_rdata, 8'hEC);

        // R4 STOP inside a byte
        bus_start();
        bus_bit(1); bus_bit(0); bus_bit(1);
        bus_stop();
        chk("R4 stop mid-byte", status, 8'h00);

        // R4 START inside a byte, then a clean STOP
        bus_start();
        bus_bit(0); bus_bit(1); bus_bit(1); bus_bit(0); bus_bit(1);
        bus_start();
        chk("R4 start mid-byte", status, 8'h00);
        bus_stop();
        chk("R4 frame reopened then stop", status, 8'hA0);

        // R7 flag clear lands on the STOP post edge
        cpu_write(8'hC8);
        bus_start();
        chk("R7 pre flag", ctrl_rdata, 8'hC8);
        sda_in = 1'b0; hold(4);
        scl_in = 1'b1; hold(4);
        sda_in = 1'b1;
        hold(2);
        cpu_write(8'hC8);
        chk("R7 flag kept on collision", ctrl_rdata, 8'hC8);
        chk("R7 status on collision", status, 8'hA0);

        // R10 disable with STOP request pending
        cpu_write(8'hC8);
        cpu_write(8'h90);
        hold(2);
        chk("R10 idle code after disable", status, 8'hF8);
        bus_start(); bus_bit(1); bus_stop();
        chk("R10 request kept while disabled", ctrl_rdata, 8'h90);
        chk("R10 status still idle", status, 8'hF8);
        chk("R6 irq with flag low", {7'd0, irq}, 8'h00);

        hold(4);
        finish_run();
    end

endmodule